// File: doc/BRIEF.md
# PCI Command/Status Error Register

This block is the error-reporting part of the command/status word of a PCI agent, as the host sees it. It holds one read/write enable for system-error signalling and fixed capability and timing fields. It also holds four sticky status flags. The bus logic raises these flags with single-cycle event strobes, and the host clears them by writing ones. The block drives the system-error line of the bus as an open-drain style pair: an active-low level and an output enable. It pulses that pair for one clock when a qualifying error occurs and system-error signalling is enabled.

The word is always visible on a 32-bit read port. The write port takes a full 32-bit word with no byte lanes, so every write acts on all implemented bits at once. Status flags take events only while the interface operates in PCI mode. Writes are accepted in either mode. There is no data stream, so all pins are plain control and status signals with no handshake. A write strobe is taken in the cycle it is high.

Top module: `pci_csr_core`

## Requirements
- R1: Synchronous active-low reset leaves `rd_data` = 32'h0280_0000, `serr_oe` = 0 and `serr_n` = 1.
- R2: Bit 8 of `rd_data` is the system-error enable. A write (`wr_en`=1) loads it from `wr_data[8]`, and it reads back in the following cycle.
- R3: Bit 23 always reads 1 and bits 26:25 always read 2'b01 (medium select timing). Every bit other than 8, 23, 24, 25, 26, 27, 28 and 30 reads 0. Writes change none of these bits.
- R4: Bit 24 (parity reported) sets when `ev_mst_dperr` is high, or when `ev_perr_seen` and `perr_resp_en` are both high. `ev_perr_seen` with `perr_resp_en` low has no effect.
- R5: Bit 27 (target abort signalled) sets on `ev_tabt_issued`. Bit 28 (target abort received) sets on `ev_tabt_rcvd`.
- R6: Bits 24, 27, 28 and 30 clear when written with 1. Writing 0 to any of them leaves it unchanged.
- R7: If a set event and a write of 1 hit the same status bit in the same cycle, the bit ends up set.
- R8: While `pci_mode` is 0, no event sets any status bit and no system-error pulse is produced.
- R9: With bit 8 set and `pci_mode` high, a system-error trigger drives `serr_oe`=1 and `serr_n`=0 in the next cycle and sets bit 30 (system error signalled). A trigger is either `ev_addr_perr`, or the first cycle in which `force_serr` and `agent_active` are both high. `force_serr` without `agent_active` is no trigger.
- R10: With bit 8 clear, `serr_oe` stays 0 and no trigger sets bit 30.
- R11: A pulse lasts exactly one clock. A trigger in the cycle the pulse is on does not start a new pulse. Holding `force_serr` high gives only one pulse. `serr_n` is 1 whenever `serr_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pci_mode | input | 1 | Interface operates in PCI mode |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write word |
| rd_data | output | 32 | Current register word |
| perr_resp_en | input | 1 | Parity-error response enable from the command register |
| ev_addr_perr | input | 1 | Address parity error detected (strobe) |
| ev_mst_dperr | input | 1 | Data parity error detected while bus master (strobe) |
| ev_perr_seen | input | 1 | Parity-error line sampled asserted (strobe) |
| ev_tabt_issued | input | 1 | Transaction ended with target-abort as target (strobe) |
| ev_tabt_rcvd | input | 1 | Own transaction ended with target-abort as master (strobe) |
| force_serr | input | 1 | Forced system-error control level |
| agent_active | input | 1 | Agent is active on the bus |
| serr_n | output | 1 | System-error line value, active low |
| serr_oe | output | 1 | System-error line output enable |

## Verification
On every cycle, the assertions check that the pulse is a single clock, that the line enable rises only when the enable bit was set, that `serr_n` is high when undriven, that the fixed and unused fields hold their values, and that no status bit rises outside PCI mode. Some behaviour only the bench scenarios can show. These are the exact event conditions that set each flag, including `ev_perr_seen` being ignored without its response enable. They also cover write-one clearing against write-zero, set winning over a same-cycle clear, the edge behaviour of a held forced error, and the reset value after activity.

// File: rtl/pci_csr_pkg.sv
package pci_csr_pkg;
  localparam int CSR_W = 32;

  // implemented bit positions
  localparam int BIT_SERR_EN    = 8;
  localparam int BIT_FBB_CAP    = 23;
  localparam int BIT_PAR_RPT    = 24;
  localparam int BIT_DEVSEL_LO  = 25;
  localparam int BIT_DEVSEL_HI  = 26;
  localparam int BIT_TABT_SIG   = 27;
  localparam int BIT_TABT_RCV   = 28;
  localparam int BIT_SYSERR_SIG = 30;

  localparam logic [1:0] DEVSEL_MEDIUM = 2'b01;

  // sticky write-one-to-clear flags
  localparam int N_STICKY = 4;
  localparam int IDX_PAR_RPT    = 0;
  localparam int IDX_TABT_SIG   = 1;
  localparam int IDX_TABT_RCV   = 2;
  localparam int IDX_SYSERR_SIG = 3;

  function automatic int sticky_pos(input int idx);
    case (idx)
      IDX_PAR_RPT:  return BIT_PAR_RPT;
      IDX_TABT_SIG: return BIT_TABT_SIG;
      IDX_TABT_RCV: return BIT_TABT_RCV;
      default:      return BIT_SYSERR_SIG;
    endcase
  endfunction

  // constant part of the word
  function automatic logic [CSR_W-1:0] fixed_word();
    logic [CSR_W-1:0] w;
    w = '0;
    w[BIT_FBB_CAP] = 1'b1;
    w[BIT_DEVSEL_HI:BIT_DEVSEL_LO] = DEVSEL_MEDIUM;
    return w;
  endfunction

  // bits the host write port acts on
  function automatic logic [CSR_W-1:0] write_mask();
    logic [CSR_W-1:0] w;
    w = '0;
    w[BIT_SERR_EN] = 1'b1;
    for (int i = 0; i < N_STICKY; i++) w[sticky_pos(i)] = 1'b1;
    return w;
  endfunction

  typedef struct packed {
    logic addr_perr;
    logic mst_dperr;
    logic perr_seen;
    logic tabt_issued;
    logic tabt_rcvd;
  } bus_evt_t;
endpackage

// File: rtl/pci_csr_sticky_bit.sv
module pci_csr_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority so that an event is never lost
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/pci_csr_evt_qual.sv
module pci_csr_evt_qual
  import pci_csr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pci_mode,
  input  logic                serr_en,
  input  logic                serr_busy,
  input  logic                perr_resp_en,
  input  bus_evt_t            evt,
  input  logic                force_serr,
  input  logic                agent_active,
  output logic [N_STICKY-1:0] set_vec,
  output logic                serr_trig,
  output logic                serr_fire
);
  logic force_lvl, force_lvl_q, force_edge;

  assign force_lvl  = force_serr & agent_active;
  assign force_edge = force_lvl & ~force_lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) force_lvl_q <= 1'b0;
    else        force_lvl_q <= force_lvl;
  end

  always_comb begin
    serr_trig = pci_mode & serr_en & (evt.addr_perr | force_edge);
    set_vec = '0;
    set_vec[IDX_PAR_RPT]    = pci_mode & (evt.mst_dperr | (evt.perr_seen & perr_resp_en));
    set_vec[IDX_TABT_SIG]   = pci_mode & evt.tabt_issued;
    set_vec[IDX_TABT_RCV]   = pci_mode & evt.tabt_rcvd;
    set_vec[IDX_SYSERR_SIG] = serr_trig;
    // a trigger during an active pulse is merged into it
    serr_fire = serr_trig & ~serr_busy;
  end
endmodule

// File: rtl/pci_csr_serr_drv.sv
module pci_csr_serr_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic busy_o,
  output logic serr_oe_o,
  output logic serr_n_o
);
  logic oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= fire_i;
  end

  assign busy_o    = oe_q;
  assign serr_oe_o = oe_q;
  assign serr_n_o  = ~oe_q;
endmodule

// File: rtl/pci_csr_core.sv
module pci_csr_core
  import pci_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pci_mode,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  output logic [CSR_W-1:0] rd_data,
  input  logic             perr_resp_en,
  input  logic             ev_addr_perr,
  input  logic             ev_mst_dperr,
  input  logic             ev_perr_seen,
  input  logic             ev_tabt_issued,
  input  logic             ev_tabt_rcvd,
  input  logic             force_serr,
  input  logic             agent_active,
  output logic             serr_n,
  output logic             serr_oe
);
  localparam logic [CSR_W-1:0] FIXED_W = fixed_word();
  localparam logic [CSR_W-1:0] WMASK   = write_mask();

  logic                serr_en_q;
  logic [N_STICKY-1:0] set_vec, clr_vec, sticky_q;
  logic                serr_trig, serr_fire, serr_busy;
  bus_evt_t            evt;

  logic unused_wr_bits;
  assign unused_wr_bits = ^(wr_data & ~WMASK) ^ serr_trig;

  assign evt = '{addr_perr:   ev_addr_perr,
                 mst_dperr:   ev_mst_dperr,
                 perr_seen:   ev_perr_seen,
                 tabt_issued: ev_tabt_issued,
                 tabt_rcvd:   ev_tabt_rcvd};

  // system-error enable, plain read/write
  always_ff @(posedge clk) begin
    if (!rst_n)     serr_en_q <= 1'b0;
    else if (wr_en) serr_en_q <= wr_data[BIT_SERR_EN];
  end

  pci_csr_evt_qual u_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .pci_mode     (pci_mode),
    .serr_en      (serr_en_q),
    .serr_busy    (serr_busy),
    .perr_resp_en (perr_resp_en),
    .evt          (evt),
    .force_serr   (force_serr),
    .agent_active (agent_active),
    .set_vec      (set_vec),
    .serr_trig    (serr_trig),
    .serr_fire    (serr_fire)
  );

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    localparam int POS = sticky_pos(g);
    assign clr_vec[g] = wr_en & wr_data[POS];
    pci_csr_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[g]),
      .clr_i (clr_vec[g]),
      .q_o   (sticky_q[g])
    );
  end

  pci_csr_serr_drv u_serr (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (serr_fire),
    .busy_o    (serr_busy),
    .serr_oe_o (serr_oe),
    .serr_n_o  (serr_n)
  );

  always_comb begin
    rd_data = FIXED_W;
    rd_data[BIT_SERR_EN] = serr_en_q;
    for (int i = 0; i < N_STICKY; i++) rd_data[sticky_pos(i)] = sticky_q[i];
  end
endmodule

// File: rtl/pci_csr_chk.sv
module pci_csr_chk
  import pci_csr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pci_mode,
  input logic [CSR_W-1:0] rd_data,
  input logic             serr_n,
  input logic             serr_oe
);
  localparam logic [CSR_W-1:0] FIXED_W = fixed_word();
  localparam logic [CSR_W-1:0] WMASK   = write_mask();

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == FIXED_W && !serr_oe));

  // R3
  fixed_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~WMASK) == FIXED_W);

  // R8
  no_set_outside_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_data[BIT_PAR_RPT]) || $rose(rd_data[BIT_TABT_SIG]) ||
     $rose(rd_data[BIT_TABT_RCV]) || $rose(rd_data[BIT_SYSERR_SIG])) |-> $past(pci_mode));

  // R10
  serr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |-> ($past(rd_data[BIT_SERR_EN]) && $past(pci_mode)));

  // R9
  serr_flags_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |-> rd_data[BIT_SYSERR_SIG]);

  // R11
  serr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |=> !serr_oe);

  // R11
  serr_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_oe |-> serr_n);
endmodule

bind pci_csr_core pci_csr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pci_mode (pci_mode),
  .rd_data  (rd_data),
  .serr_n   (serr_n),
  .serr_oe  (serr_oe)
);

// File: tb/pci_csr_core_tb.sv
module pci_csr_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pci_mode = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        perr_resp_en = 1'b0, ev_addr_perr = 1'b0, ev_mst_dperr = 1'b0;
  logic        ev_perr_seen = 1'b0, ev_tabt_issued = 1'b0, ev_tabt_rcvd = 1'b0;
  logic        force_serr = 1'b0, agent_active = 1'b0;
  logic        serr_n, serr_oe;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pci_csr_core u_dut (.*);

  typedef struct packed {
    logic        mode;
    logic        wr;
    logic [31:0] wd;
    logic        a_pe;
    logic        m_dpe;
    logic        pe_seen;
    logic        pe_resp;
    logic        t_iss;
    logic        t_rcv;
    logic        frc;
    logic        act;
    logic [31:0] exp_rd;
    logic        exp_oe;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1,1,32'hFFFF_FFFF,0,0,0,0,0,0,0,0,32'h0280_0100,0,4'd2},  // R2 R3 all-ones write
    '{1,0,32'h0,0,0,0,0,1,0,0,0,32'h0A80_0100,0,4'd5},          // R5 abort issued
    '{1,0,32'h0,0,0,0,0,0,1,0,0,32'h1A80_0100,0,4'd5},          // R5 abort received
    '{1,0,32'h0,0,0,1,0,0,0,0,0,32'h1A80_0100,0,4'd4},          // R4 perr without response enable
    '{1,0,32'h0,0,0,1,1,0,0,0,0,32'h1B80_0100,0,4'd4},          // R4 perr with response enable
    '{1,1,32'h0800_0000,0,0,0,0,0,0,0,0,32'h1380_0000,0,4'd6},  // R6 clear bit 27 (drops enable)
    '{1,1,32'h0000_0100,0,0,0,0,0,0,0,0,32'h1380_0100,0,4'd6},  // R6 zeros keep flags
    '{1,1,32'h1100_0100,0,0,0,0,0,0,0,0,32'h0280_0100,0,4'd6},  // R6 clear 24 and 28
    '{1,1,32'h0100_0100,0,1,0,0,0,0,0,0,32'h0380_0100,0,4'd7},  // R7 set beats clear
    '{0,0,32'h0,1,0,1,1,1,1,0,0,32'h0380_0100,0,4'd8},          // R8 events outside mode
    '{1,0,32'h0,1,0,0,0,0,0,0,0,32'h4380_0100,1,4'd9},          // R9 address parity trigger
    '{1,0,32'h0,1,0,0,0,0,0,0,0,32'h4380_0100,0,4'd11},         // R11 merged trigger
    '{1,0,32'h0,0,0,0,0,0,0,0,0,32'h4380_0100,0,4'd11},         // R11 idle
    '{1,0,32'h0,0,0,0,0,0,0,1,0,32'h4380_0100,0,4'd9},          // R9 force not active
    '{1,0,32'h0,0,0,0,0,0,0,1,1,32'h4380_0100,1,4'd9},          // R9 force edge
    '{1,0,32'h0,0,0,0,0,0,0,1,1,32'h4380_0100,0,4'd11},         // R11 force held
    '{1,1,32'h4000_0000,0,0,0,0,0,0,0,0,32'h0380_0000,0,4'd6},  // R6 clear bit 30, disable
    '{1,0,32'h0,1,0,0,0,0,0,0,0,32'h0380_0000,0,4'd10},         // R10 trigger disabled
    '{1,0,32'h0,0,0,0,0,0,0,1,1,32'h0380_0000,0,4'd10}          // R10 force disabled
  };

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_data = '0; ev_addr_perr = 0; ev_mst_dperr = 0; ev_perr_seen = 0;
    perr_resp_en = 0; ev_tabt_issued = 0; ev_tabt_rcvd = 0; force_serr = 0; agent_active = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk32("R1 rd_data in reset", rd_data, 32'h0280_0000);
    chk32("R1 serr_oe in reset", {31'b0, serr_oe}, 32'h0);
    chk32("R1 serr_n in reset", {31'b0, serr_n}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk32("R1 rd_data after reset", rd_data, 32'h0280_0000);

    for (int i = 0; i < NV; i++) begin
      pci_mode = VECS[i].mode; wr_en = VECS[i].wr; wr_data = VECS[i].wd;
      ev_addr_perr = VECS[i].a_pe; ev_mst_dperr = VECS[i].m_dpe;
      ev_perr_seen = VECS[i].pe_seen; perr_resp_en = VECS[i].pe_resp;
      ev_tabt_issued = VECS[i].t_iss; ev_tabt_rcvd = VECS[i].t_rcv;
      force_serr = VECS[i].frc; agent_active = VECS[i].act;
      @(negedge clk);
      chk32($sformatf("R%0d vec %0d rd_data", VECS[i].req, i), rd_data, VECS[i].exp_rd);
      chk32($sformatf("R%0d vec %0d serr_oe", VECS[i].req, i), {31'b0, serr_oe}, {31'b0, VECS[i].exp_oe});
      chk32($sformatf("R11 vec %0d serr_n", i), {31'b0, serr_n}, {31'b0, ~VECS[i].exp_oe});
    end
    idle_inputs();

    // R9 pulse sequence through its two cycles, then R11 end of pulse
    pci_mode = 1; wr_en = 1; wr_data = 32'h0000_0100;
    @(negedge clk);
    wr_en = 0; ev_addr_perr = 1;
    @(negedge clk);
    ev_addr_perr = 0;
    chk32("R9 serr_n low during pulse", {31'b0, serr_n}, 32'h0);
    @(negedge clk);
    chk32("R11 pulse ended", {31'b0, serr_oe}, 32'h0);

    // R1 reset after activity
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk32("R1 rd_data after mid-run reset", rd_data, 32'h0280_0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule